// File: doc/BRIEF.md
# Auto-Reload Interval Timer

A 16-bit down-counting interval timer for periodic synchronisation and watchdog duties. Software programs a reload value one byte at a time and then sets an enable bit. When the bit is set, the reload value is copied into the current counter. The counter then steps down once for each pulse on a timebase tick input, which runs at roughly 10 µs and is a clock enable, not a clock.

When the counter arrives at zero, a pending flag is set, and that flag drives the interrupt output. The counter is not reloaded on that same tick: it stays at zero, and the tick that follows copies the reload value in again. A reload value of N therefore gives one flag every N+1 ticks. Software clears the flag in one of two ways: by writing anything to the status address, or by writing 0 to the flag bit at the flag address.

Top module: `rt_interval_timer`

## Requirements
- R1: After reset the current count, the reload value, the enable bit and the pending flag are all zero, and `irq_o` is low.
- R2: The byte address map is: 0 is the reload low byte, 1 is the reload high byte, 2 and 3 are the current count low and high bytes (read-only), 4 is control with bit 0 as enable, 5 is status with bit 0 showing pending, and 6 is the flag register with bit 0 showing pending. Reads of any other address return 0.
- R3: A control write that takes enable from 0 to 1 loads the current count from the reload value. A write of 1 while the timer is already enabled does not reload.
- R4: Each tick while enabled lowers the current count by one, with the borrow carried from the low byte into the high byte.
- R5: The tick that brings the count to zero sets the pending flag, and `irq_o` is high from the next cycle.
- R6: The tick after the one that reached zero reloads the counter, so a reload value of N gives a flag every N+1 ticks.
- R7: Any write to the status address clears the pending flag, whatever data is written.
- R8: A write to the flag address with bit 0 equal to 0 clears the pending flag. With bit 0 equal to 1 the write has no effect.
- R9: While enable is 0, ticks are ignored: the count is frozen and no new flag is raised.
- R10: Writes to the reload bytes while the timer runs leave the current count unchanged. The new value takes effect at the next reload.
- R11: With a reload value of 0, the flag is set on every other tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase clock enable, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Pending flag, high until cleared |

## Verification
The counter is run with three reload values, and each one tells a different fault apart:
- A small value of 3 measures the N+1 period and checks that the reload happens on the tick after zero, not on the same tick.
- The value 0x0100 exposes a missing borrow from the low byte into the high byte.
- The value 0 separates the every-other-tick behaviour from a counter that sticks at zero.

Against those runs, three interleaved cases are checked:
- Reload writes made mid-count.
- Repeated enable writes.
- Ticks given while disabled.

Together they show whether the reload value, the enable edge and the freeze each act only when the requirements say they should. Flag clearing is tried through both clear paths, and once with a flag write of 1, which must leave the flag set.

// File: rtl/rt_timer_pkg.sv
package rt_timer_pkg;

  typedef enum logic [2:0] {
    SEL_RELOAD,
    SEL_COUNT,
    SEL_CTRL,
    SEL_STAT,
    SEL_FLAG,
    SEL_NONE
  } rt_sel_e;

  // Address decode: reload bytes, count bytes, then control, status, flag.
  function automatic rt_sel_e rt_decode(input int unsigned a, input int unsigned nbytes);
    if (a < nbytes)                return SEL_RELOAD;
    else if (a < 2 * nbytes)       return SEL_COUNT;
    else if (a == 2 * nbytes)      return SEL_CTRL;
    else if (a == 2 * nbytes + 1)  return SEL_STAT;
    else if (a == 2 * nbytes + 2)  return SEL_FLAG;
    else                           return SEL_NONE;
  endfunction

endpackage

// File: rtl/rt_regs.sv
module rt_regs
  import rt_timer_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 2,
  parameter int ADDR_W    = 3,
  localparam int CNT_W    = DATA_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  reload_val,
  output logic              enable,
  output logic              en_rise,
  output logic              stat_wr,
  output logic              flag_clr_wr
);

  rt_sel_e sel;
  logic    ctrl_wr;

  assign sel         = rt_decode(32'(addr), NUM_BYTES);
  assign ctrl_wr     = wr_en && (sel == SEL_CTRL);
  assign en_rise     = ctrl_wr && wdata[0] && !enable;
  assign stat_wr     = wr_en && (sel == SEL_STAT);
  assign flag_clr_wr = wr_en && (sel == SEL_FLAG) && !wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n)       enable <= 1'b0;
    else if (ctrl_wr) enable <= wdata[0];
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_rel
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        byte_q <= '0;
      else if (wr_en && (sel == SEL_RELOAD) && (32'(addr) == g))
        byte_q <= wdata;
    end
    assign reload_val[g*DATA_W +: DATA_W] = byte_q;
  end

endmodule

// File: rtl/rt_core.sv
module rt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             en_rise,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             dec_evt,
  output logic             zero_evt,
  output logic             reload_evt
);

  logic wrap_q;
  logic active;

  function automatic logic [CNT_W-1:0] f_dec(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  function automatic logic f_reaches_zero(input logic [CNT_W-1:0] c);
    return (c == CNT_W'(1)) || (c == '0);
  endfunction

  assign active     = enable && tick && !en_rise;
  assign reload_evt = active && wrap_q;
  assign zero_evt   = active && !wrap_q && f_reaches_zero(count);
  assign dec_evt    = active && !wrap_q && (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      wrap_q <= 1'b0;
    end else if (en_rise || reload_evt) begin
      count  <= reload_val;
      wrap_q <= 1'b0;
    end else begin
      if (dec_evt)  count  <= f_dec(count);
      if (zero_evt) wrap_q <= 1'b1;
    end
  end

endmodule

// File: rtl/rt_flag.sv
module rt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_evt,
  input  logic stat_wr,
  input  logic flag_clr_wr,
  output logic pending
);

  always_ff @(posedge clk) begin
    if (!rst_n)                      pending <= 1'b0;
    else if (zero_evt)               pending <= 1'b1;
    else if (stat_wr || flag_clr_wr) pending <= 1'b0;
  end

endmodule

// File: rtl/rt_interval_timer.sv
module rt_interval_timer
  import rt_timer_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 2,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  localparam int CNT_W = DATA_W * NUM_BYTES;

  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] count;
  logic             enable, en_rise, stat_wr, flag_clr_wr;
  logic             dec_evt, zero_evt, reload_evt, pending;
  rt_sel_e          rd_sel;

  rt_regs #(.DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
    .reload_val(reload_val), .enable(enable), .en_rise(en_rise),
    .stat_wr(stat_wr), .flag_clr_wr(flag_clr_wr)
  );

  rt_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .enable(enable), .en_rise(en_rise),
    .reload_val(reload_val), .count(count), .dec_evt(dec_evt),
    .zero_evt(zero_evt), .reload_evt(reload_evt)
  );

  rt_flag flag_i (
    .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt), .stat_wr(stat_wr),
    .flag_clr_wr(flag_clr_wr), .pending(pending)
  );

  assign irq_o  = pending;
  assign rd_sel = rt_decode(32'(addr_i), NUM_BYTES);

  always_comb begin
    rdata_o = '0;
    unique case (rd_sel)
      SEL_CTRL: rdata_o[0] = enable;
      SEL_STAT: rdata_o[0] = pending;
      SEL_FLAG: rdata_o[0] = pending;
      SEL_RELOAD, SEL_COUNT: begin
        for (int b = 0; b < NUM_BYTES; b++) begin
          if (32'(addr_i) == b)             rdata_o = reload_val[b*DATA_W +: DATA_W];
          if (32'(addr_i) == NUM_BYTES + b) rdata_o = count[b*DATA_W +: DATA_W];
        end
      end
      default: rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/rt_interval_timer_chk.sv
module rt_interval_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             en_rise,
  input logic             dec_evt,
  input logic             zero_evt,
  input logic             reload_evt,
  input logic             stat_wr,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload_val
);

  AST_LOAD_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (enable && count == $past(reload_val))); // R3

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec_evt |=> (count == CNT_W'($past(count) - CNT_W'(1)))); // R4

  AST_FLAG_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> irq); // R5

  AST_RELOAD_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> (count == $past(reload_val))); // R6

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !zero_evt) |=> !irq); // R7

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !en_rise) |=> $stable(count)); // R9

  AST_NO_FLAG_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> enable); // R9

endmodule

bind rt_interval_timer rt_interval_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .en_rise(en_rise),
  .dec_evt(dec_evt), .zero_evt(zero_evt), .reload_evt(reload_evt),
  .stat_wr(stat_wr), .irq(irq_o), .count(count), .reload_val(reload_val)
);

// File: tb/rt_interval_timer_tb_top.sv
module rt_interval_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sb_q[$];

  always #5 clk = ~clk;

  rt_interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // Monitor: samples one cycle after the driver queued an item.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {7'b0, irq_o} : rdata_o;
        n_checks++;
        if (act !== it.exp) begin
          n_fails++;
          $display("FAIL %s: got %0h expected %0h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step();
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      step(); tick_i = 1'b1;
      step(); tick_i = 1'b0;
    end
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [7:0] e, input string req);
    step();
    addr_i = a;
    sb_q.push_back('{1'b0, e, req});
  endtask

  task automatic chk_irq(input bit e, input string req);
    step();
    sb_q.push_back('{1'b1, {7'b0, e}, req});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_rd(3'd2, 8'h00, "R1 count lo");
    chk_rd(3'd4, 8'h00, "R1 ctrl");
    chk_rd(3'd0, 8'h00, "R1 reload lo");
    chk_irq(1'b0, "R1 irq");
    // R3 load on enable
    wr(3'd0, 8'd3); wr(3'd1, 8'd0);
    chk_rd(3'd2, 8'h00, "R10 count before enable");
    wr(3'd4, 8'h01);
    chk_rd(3'd2, 8'h03, "R3 load on enable");
    chk_rd(3'd4, 8'h01, "R2 ctrl readback");
    // R4 / R5
    tk(1); chk_rd(3'd2, 8'h02, "R4 first step");
    tk(1); chk_rd(3'd2, 8'h01, "R4 second step"); chk_irq(1'b0, "R5 no early flag");
    tk(1); chk_rd(3'd2, 8'h00, "R5 count zero"); chk_irq(1'b1, "R5 flag set");
    chk_rd(3'd5, 8'h01, "R2 status shows pending");
    chk_rd(3'd6, 8'h01, "R2 flag reg shows pending");
    // R7 status write clears
    wr(3'd5, 8'hA5); chk_irq(1'b0, "R7 status write clears");
    // R6 reload on next tick, period N+1
    tk(1); chk_rd(3'd2, 8'h03, "R6 reload after zero"); chk_irq(1'b0, "R6 no flag on reload");
    tk(2); chk_irq(1'b0, "R6 not yet");
    tk(1); chk_irq(1'b1, "R6 period");
    // R8 flag register writes
    wr(3'd6, 8'h01); chk_irq(1'b1, "R8 write one ignored");
    wr(3'd6, 8'h00); chk_irq(1'b0, "R8 write zero clears");
    // R3 repeated enable does not reload
    wr(3'd4, 8'h01); chk_rd(3'd2, 8'h00, "R3 no reload when already on");
    tk(1); chk_rd(3'd2, 8'h03, "R6 reload");
    // R10 reload change mid-run
    wr(3'd0, 8'd5); chk_rd(3'd2, 8'h03, "R10 count unchanged");
    tk(3); chk_irq(1'b1, "R10 old period kept");
    wr(3'd5, 8'h00);
    tk(1); chk_rd(3'd2, 8'h05, "R10 new value at reload");
    // R9 freeze
    tk(1); chk_rd(3'd2, 8'h04, "R4 step");
    wr(3'd4, 8'h00);
    tk(5); chk_rd(3'd2, 8'h04, "R9 frozen"); chk_irq(1'b0, "R9 no flag when off");
    wr(3'd4, 8'h01); chk_rd(3'd2, 8'h05, "R3 re-enable reloads");
    // R4 borrow across bytes
    wr(3'd4, 8'h00); wr(3'd0, 8'h00); wr(3'd1, 8'h01); wr(3'd4, 8'h01);
    chk_rd(3'd3, 8'h01, "R4 hi before");
    tk(1); chk_rd(3'd2, 8'hFF, "R4 borrow lo"); chk_rd(3'd3, 8'h00, "R4 borrow hi");
    // R11 reload zero
    wr(3'd4, 8'h00); wr(3'd1, 8'h00); wr(3'd4, 8'h01);
    chk_rd(3'd2, 8'h00, "R11 loaded zero"); chk_irq(1'b0, "R11 no flag yet");
    tk(1); chk_irq(1'b1, "R11 first flag");
    wr(3'd5, 8'h00);
    tk(1); chk_irq(1'b0, "R11 reload tick");
    tk(1); chk_irq(1'b1, "R11 second flag");
    // R2 unmapped address
    chk_rd(3'd7, 8'h00, "R2 unmapped reads zero");
    step(); step();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule